// File: doc/BRIEF.md
# PLL Coefficient Change Sequencer

This block steps a phase-locked loop from one set of divider coefficients (reference divider M, feedback divider N, post divider PL) to a new set without letting the output clock glitch or overshoot. When only the feedback divider changes and the loop is already running, it asks a separate ramp controller to glide N to the new value. In every other case it performs a full relock. It first glides N down to the value that places the VCO at its floor frequency. It then halves the output through a temporary divide-by-2, moves the clock tree onto the bypass path, powers the loop up if needed, and disables it. Next it loads the new coefficients, re-enables the loop and waits for lock. Finally it returns to the VCO path, restores 1:1 division and glides up to the target N.

The ramp controller is driven through a level request with a target N and answers with a done or a timeout pulse. A free-running one-microsecond tick times the settle delays and the lock window. The reference frequency, in MHz, sets the floor N = ceil(M × VCO_MIN_MHZ / ref). If an attempt that uses gliding fails, the whole sequence runs once more with gliding disabled. A second failure raises `error` and leaves the output on bypass. A shutdown command glides down, selects bypass and switches the loop off.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset: pll_en=0, pll_pwrdn=1, lock_det_off=1, vco_sel=0 (bypass), vco_div=0, byp_div=0x3c, div_mode=1, busy=0, error=0, done=0.
- R2: A start with gliding allowed, pll_en=1, and new M and PL equal to coef_m and coef_pl runs a glide-only change. It makes one ramp request to new_n and does not touch vco_sel or pll_en.
- R3: The floor N is ceil(M × VCO_MIN_MHZ / ref_mhz). In a gliding full relock with the loop enabled, the first ramp request targets the floor N of the old M.
- R4: In a full relock, vco_div is set to 2 and vco_sel is cleared to 0 no sooner than SETTLE_US ticks later. The loop is re-enabled only with vco_sel=0 and vco_div=2.
- R5: If pll_pwrdn is 1 when a relock reaches power-up, it is cleared before the loop is disabled and it never returns to 1.
- R6: Coefficients change only while pll_en=0. The loaded N is the floor N of the new M when gliding is allowed, else new_n. pll_en is then set to 1.
- R7: lock_det_off is cleared after re-enable. Lock is awaited for LOCK_US ticks, and expiry fails the attempt.
- R8: After lock, vco_sel=1 and, SETTLE_US ticks later, vco_div=0. With gliding allowed, a ramp request to new_n follows.
- R9: A failed first attempt (lock expiry or ramp timeout) is followed by a second full relock with no ramp requests, which loads new_n directly.
- R10: If the second attempt fails, error=1 is raised with the done pulse, the block returns idle with vco_sel=0 and vco_div=2.
- R11: A shutdown from an enabled loop makes one ramp request to the floor N of coef_m, then sets vco_sel=0 and pll_en=0. From a disabled loop it makes no ramp request.
- R12: start and shutdown are ignored while busy=1.
- R13: A glide whose target equals coef_n makes no ramp request.
- R14: ramp_req is asserted only while pll_en=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| ref_mhz | input | REF_W | Reference clock frequency in MHz |
| start | input | 1 | Begin a coefficient change (sampled when idle) |
| new_m | input | M_W | Target reference divider |
| new_n | input | N_W | Target feedback divider |
| new_pl | input | PL_W | Target post divider code |
| shutdown | input | 1 | Begin a safe power-off (sampled when idle) |
| pll_lock | input | 1 | Loop lock status |
| ramp_done | input | 1 | Ramp controller finished pulse |
| ramp_timeout | input | 1 | Ramp controller timed-out pulse |
| ramp_req | output | 1 | Glide request, held until done or timeout |
| ramp_n | output | N_W | Glide target N |
| coef_m | output | M_W | Programmed M |
| coef_n | output | N_W | Programmed N |
| coef_pl | output | PL_W | Programmed post divider code |
| pll_en | output | 1 | Loop enable |
| pll_pwrdn | output | 1 | Loop power-down |
| lock_det_off | output | 1 | Lock detector disable |
| vco_sel | output | 1 | 1 = VCO path, 0 = bypass path |
| vco_div | output | DIV_W | VCO output divider field (0 = 1:1, 2 = 1:2) |
| byp_div | output | DIV_W | Bypass path divider field |
| div_mode | output | 1 | Output divider mode bit |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse at sequence end |
| error | output | 1 | Last sequence failed both attempts |

## Verification
A table of seven back-to-back coefficient changes covers the main paths. These are a first relock from a disabled loop, a glide-only change, a relock that glides down then up, and a glide-only request to the N already loaded. They also include a lock expiry recovered by the non-gliding retry, a double lock expiry and a ramp timeout recovered by relock. The ramp targets in order, the number of enable rises and the N loaded at the last enable separate the glide-only, gliding-relock and retry paths. They show whether the floor N used the old or the new M. Directed tests then check shutdown from enabled and disabled states and commands issued while busy. They also check the settle gap before bypass and the length of the lock window.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [4:0] {
    S_IDLE,
    S_CHK,
    S_CALC_OLD,
    S_HALVE,
    S_BYP_WAIT,
    S_PWRUP,
    S_PWRUP_WAIT,
    S_DISABLE,
    S_CALC_NEW,
    S_ENABLE,
    S_UNMASK,
    S_LOCK_WAIT,
    S_REST_WAIT,
    S_SLIDE_REQ,
    S_SLIDE_WAIT,
    S_FAIL,
    S_FINISH,
    S_SD_GO,
    S_SD_CALC,
    S_SD_BYP,
    S_SD_OFF
  } seq_state_e;

endpackage

// File: rtl/pll_ceil_div.sv
// Iterative restoring divider returning ceil(num/den), saturated to Q_W bits.
module pll_ceil_div #(
  parameter int NUM_W = 18,
  parameter int DEN_W = 8,
  parameter int Q_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [Q_W-1:0]   q
);
  localparam int CNT_W = $clog2(NUM_W + 1);
  localparam logic [NUM_W:0] QMAX = (NUM_W+1)'({Q_W{1'b1}});

  logic [NUM_W-1:0] sh;
  logic [NUM_W-1:0] quo;
  logic [DEN_W:0]   rem;
  logic [DEN_W-1:0] den_q;
  logic [CNT_W-1:0] left;
  logic [DEN_W:0]   trial;
  logic [NUM_W:0]   up;

  assign trial = {rem[DEN_W-1:0], sh[NUM_W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      quo   <= '0;
      rem   <= '0;
      den_q <= '0;
      left  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        sh    <= num;
        den_q <= den;
        quo   <= '0;
        rem   <= '0;
        left  <= CNT_W'(NUM_W);
      end else if (left != '0) begin
        if (trial >= {1'b0, den_q}) begin
          rem <= trial - {1'b0, den_q};
          quo <= {quo[NUM_W-2:0], 1'b1};
        end else begin
          rem <= trial;
          quo <= {quo[NUM_W-2:0], 1'b0};
        end
        sh   <= {sh[NUM_W-2:0], 1'b0};
        left <= left - 1'b1;
        if (left == CNT_W'(1)) done <= 1'b1;
      end
    end
  end

  always_comb begin
    up = {1'b0, quo} + (NUM_W+1)'(rem != '0);
    q  = (up > QMAX) ? {Q_W{1'b1}} : up[Q_W-1:0];
  end

endmodule

// File: rtl/pll_us_timer.sv
// Down-counter advanced by the microsecond tick.
module pll_us_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= val;
    else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int          M_W          = 8,
  parameter int          N_W          = 8,
  parameter int          PL_W         = 6,
  parameter int          REF_W        = 8,
  parameter int          DIV_W        = 6,
  parameter int          VCO_MIN_MHZ  = 1000,
  parameter int          LOCK_US      = 300,
  parameter int          SETTLE_US    = 2,
  parameter int          VCO_DIV_HALF = 2,
  parameter logic [5:0]  BYP_DIV_INIT = 6'h3c
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             us_tick,
  input  logic [REF_W-1:0] ref_mhz,
  input  logic             start,
  input  logic [M_W-1:0]   new_m,
  input  logic [N_W-1:0]   new_n,
  input  logic [PL_W-1:0]  new_pl,
  input  logic             shutdown,
  input  logic             pll_lock,
  input  logic             ramp_done,
  input  logic             ramp_timeout,
  output logic             ramp_req,
  output logic [N_W-1:0]   ramp_n,
  output logic [M_W-1:0]   coef_m,
  output logic [N_W-1:0]   coef_n,
  output logic [PL_W-1:0]  coef_pl,
  output logic             pll_en,
  output logic             pll_pwrdn,
  output logic             lock_det_off,
  output logic             vco_sel,
  output logic [DIV_W-1:0] vco_div,
  output logic [DIV_W-1:0] byp_div,
  output logic             div_mode,
  output logic             busy,
  output logic             done,
  output logic             error
);
  localparam int VMIN_W = $clog2(VCO_MIN_MHZ + 1);
  localparam int NUM_W  = M_W + VMIN_W;
  localparam int TMAX   = (LOCK_US > SETTLE_US) ? LOCK_US : SETTLE_US;
  localparam int TMR_W  = $clog2(TMAX + 1);

  seq_state_e st, slide_ret;
  logic [M_W-1:0]  tm;
  logic [N_W-1:0]  tn;
  logic [PL_W-1:0] tpl;
  logic            allow;
  logic            sd_mode;

  logic             slide_only, go_down;
  logic             div_go, div_done;
  logic [M_W-1:0]   div_m;
  logic [NUM_W-1:0] div_num;
  logic [N_W-1:0]   div_q;
  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;

  // Path choice and helper-unit control decoded from the current state
  always_comb begin
    slide_only = allow && pll_en && (tm == coef_m) && (tpl == coef_pl);
    go_down    = allow && pll_en && !slide_only;
    div_go     = (st == S_CHK && go_down) || (st == S_DISABLE) || (st == S_SD_GO);
    div_m      = (st == S_DISABLE) ? tm : coef_m;
    div_num    = NUM_W'(div_m) * NUM_W'(VCO_MIN_MHZ);
    tmr_load   = (st == S_HALVE) || (st == S_UNMASK) ||
                 (st == S_PWRUP && pll_pwrdn) ||
                 (st == S_LOCK_WAIT && pll_lock);
    tmr_val    = (st == S_UNMASK) ? TMR_W'(LOCK_US) : TMR_W'(SETTLE_US);
  end

  pll_ceil_div #(.NUM_W(NUM_W), .DEN_W(REF_W), .Q_W(N_W)) u_floor_div (
    .clk  (clk),
    .rst  (rst),
    .go   (div_go),
    .num  (div_num),
    .den  (ref_mhz),
    .done (div_done),
    .q    (div_q)
  );

  pll_us_timer #(.CNT_W(TMR_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (us_tick),
    .load (tmr_load),
    .val  (tmr_val),
    .zero (tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      slide_ret    <= S_IDLE;
      tm           <= '0;
      tn           <= '0;
      tpl          <= '0;
      allow        <= 1'b0;
      sd_mode      <= 1'b0;
      ramp_req     <= 1'b0;
      ramp_n       <= '0;
      coef_m       <= '0;
      coef_n       <= '0;
      coef_pl      <= '0;
      pll_en       <= 1'b0;
      pll_pwrdn    <= 1'b1;
      lock_det_off <= 1'b1;
      vco_sel      <= 1'b0;
      vco_div      <= '0;
      byp_div      <= DIV_W'(BYP_DIV_INIT);
      div_mode     <= 1'b1;
      busy         <= 1'b0;
      done         <= 1'b0;
      error        <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            tm    <= new_m;
            tn    <= new_n;
            tpl   <= new_pl;
            allow <= 1'b1;
            error <= 1'b0;
            busy  <= 1'b1;
            st    <= S_CHK;
          end else if (shutdown) begin
            busy    <= 1'b1;
            sd_mode <= 1'b1;
            st      <= pll_en ? S_SD_GO : S_SD_BYP;
          end
        end
        S_CHK: begin
          if (slide_only) begin
            ramp_n    <= tn;
            slide_ret <= S_FINISH;
            st        <= S_SLIDE_REQ;
          end else if (go_down) begin
            st <= S_CALC_OLD;
          end else begin
            st <= S_HALVE;
          end
        end
        S_CALC_OLD: begin
          if (div_done) begin
            ramp_n    <= div_q;
            slide_ret <= S_HALVE;
            st        <= S_SLIDE_REQ;
          end
        end
        S_HALVE: begin
          vco_div <= DIV_W'(VCO_DIV_HALF);
          st      <= S_BYP_WAIT;
        end
        S_BYP_WAIT: begin
          if (tmr_zero) begin
            vco_sel <= 1'b0;
            st      <= S_PWRUP;
          end
        end
        S_PWRUP: begin
          if (pll_pwrdn) begin
            pll_pwrdn <= 1'b0;
            st        <= S_PWRUP_WAIT;
          end else begin
            st <= S_DISABLE;
          end
        end
        S_PWRUP_WAIT: begin
          if (tmr_zero) st <= S_DISABLE;
        end
        S_DISABLE: begin
          pll_en <= 1'b0;
          st     <= S_CALC_NEW;
        end
        S_CALC_NEW: begin
          if (div_done) begin
            coef_m  <= tm;
            coef_pl <= tpl;
            coef_n  <= allow ? div_q : tn;
            st      <= S_ENABLE;
          end
        end
        S_ENABLE: begin
          pll_en <= 1'b1;
          st     <= S_UNMASK;
        end
        S_UNMASK: begin
          lock_det_off <= 1'b0;
          st           <= S_LOCK_WAIT;
        end
        S_LOCK_WAIT: begin
          if (pll_lock) begin
            vco_sel <= 1'b1;
            st      <= S_REST_WAIT;
          end else if (tmr_zero) begin
            st <= S_FAIL;
          end
        end
        S_REST_WAIT: begin
          if (tmr_zero) begin
            vco_div <= '0;
            if (allow) begin
              ramp_n    <= tn;
              slide_ret <= S_FINISH;
              st        <= S_SLIDE_REQ;
            end else begin
              st <= S_FINISH;
            end
          end
        end
        S_SLIDE_REQ: begin
          if (ramp_n == coef_n) begin
            st <= slide_ret;
          end else begin
            coef_n   <= ramp_n;
            ramp_req <= 1'b1;
            st       <= S_SLIDE_WAIT;
          end
        end
        S_SLIDE_WAIT: begin
          if (ramp_done) begin
            ramp_req <= 1'b0;
            st       <= slide_ret;
          end else if (ramp_timeout) begin
            ramp_req <= 1'b0;
            st       <= sd_mode ? slide_ret : S_FAIL;
          end
        end
        S_FAIL: begin
          if (allow) begin
            allow <= 1'b0;
            st    <= S_CHK;
          end else begin
            error <= 1'b1;
            done  <= 1'b1;
            busy  <= 1'b0;
            st    <= S_IDLE;
          end
        end
        S_SD_GO: begin
          st <= S_SD_CALC;
        end
        S_SD_CALC: begin
          if (div_done) begin
            ramp_n    <= div_q;
            slide_ret <= S_SD_BYP;
            st        <= S_SLIDE_REQ;
          end
        end
        S_SD_BYP: begin
          vco_sel <= 1'b0;
          st      <= S_SD_OFF;
        end
        S_SD_OFF: begin
          pll_en  <= 1'b0;
          sd_mode <= 1'b0;
          st      <= S_FINISH;
        end
        S_FINISH: begin
          done <= 1'b1;
          busy <= 1'b0;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk #(
  parameter int M_W   = 8,
  parameter int DIV_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             pll_lock,
  input logic             vco_sel,
  input logic             pll_en,
  input logic             pll_pwrdn,
  input logic [M_W-1:0]   coef_m,
  input logic [DIV_W-1:0] vco_div,
  input logic             ramp_req,
  input logic             done,
  input logic             error
);

  // R8
  sel_after_lock_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vco_sel) |-> $past(pll_lock));

  // R6
  coef_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(coef_m) |-> !pll_en);

  // R4
  enable_in_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_en) |-> (!vco_sel && vco_div == DIV_W'(2)));

  // R14
  ramp_when_on_chk: assert property (@(posedge clk) disable iff (rst)
    ramp_req |-> pll_en);

  // R5
  pwrdn_no_return_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(pll_pwrdn));

  // R10
  error_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(error) |-> (done && !vco_sel));

endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(.M_W(M_W), .DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pll_lock  (pll_lock),
  .vco_sel   (vco_sel),
  .pll_en    (pll_en),
  .pll_pwrdn (pll_pwrdn),
  .coef_m    (coef_m),
  .vco_div   (vco_div),
  .ramp_req  (ramp_req),
  .done      (done),
  .error     (error)
);

// File: tb/pll_reprog_seq_tb.sv
module pll_reprog_seq_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic us_tick = 1'b0;
  logic [7:0] ref_mhz = 8'd12;
  logic start = 1'b0;
  logic [7:0] new_m = '0;
  logic [7:0] new_n = '0;
  logic [5:0] new_pl = '0;
  logic shutdown = 1'b0;
  logic pll_lock = 1'b0;
  logic ramp_done = 1'b0;
  logic ramp_timeout = 1'b0;
  logic ramp_req;
  logic [7:0] ramp_n, coef_m, coef_n;
  logic [5:0] coef_pl, vco_div, byp_div;
  logic pll_en, pll_pwrdn, lock_det_off, vco_sel, div_mode, busy, done, error;

  always #2 clk = ~clk;

  pll_reprog_seq u_dut (
    .clk(clk), .rst(rst), .us_tick(us_tick), .ref_mhz(ref_mhz),
    .start(start), .new_m(new_m), .new_n(new_n), .new_pl(new_pl),
    .shutdown(shutdown), .pll_lock(pll_lock), .ramp_done(ramp_done),
    .ramp_timeout(ramp_timeout), .ramp_req(ramp_req), .ramp_n(ramp_n),
    .coef_m(coef_m), .coef_n(coef_n), .coef_pl(coef_pl), .pll_en(pll_en),
    .pll_pwrdn(pll_pwrdn), .lock_det_off(lock_det_off), .vco_sel(vco_sel),
    .vco_div(vco_div), .byp_div(byp_div), .div_mode(div_mode),
    .busy(busy), .done(done), .error(error)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Environment models and monitors, all on the falling edge
  int tick_div = 0;
  int rwait = 0;
  int lwait = 0;
  int rcnt = 0;
  int en_rises = 0;
  int sel_falls = 0;
  int lock_thr = 0;
  int ramp_thr = 0;
  int gap_ticks = 0;
  int min_gap = 99;
  int en_ticks = 0;
  int last_en_ticks = 0;
  logic [7:0] en_n = '0;
  logic [7:0] rlog [0:63];
  logic p_req = 1'b0, p_en = 1'b0, p_sel = 1'b0;
  logic [5:0] p_div = '0;

  always @(negedge clk) begin
    us_tick      <= (tick_div == 3);
    tick_div     <= (tick_div + 1) % 4;
    ramp_done    <= 1'b0;
    ramp_timeout <= 1'b0;
    if (!rst) begin
      if (!ramp_req) rwait <= 0;
      else if (rwait == 3) begin
        if (rcnt <= ramp_thr) ramp_timeout <= 1'b1;
        else ramp_done <= 1'b1;
        rwait <= 4;
      end else if (rwait < 3) rwait <= rwait + 1;

      if (!pll_en || lock_det_off) begin
        lwait <= 0; pll_lock <= 1'b0;
      end else if (lwait < 5) lwait <= lwait + 1;
      else pll_lock <= (en_rises > lock_thr);

      if (ramp_req && !p_req) begin
        rlog[rcnt % 64] <= ramp_n;
        rcnt <= rcnt + 1;
      end
      if (pll_en && !p_en) begin
        en_rises <= en_rises + 1; en_n <= coef_n; en_ticks <= 0;
      end else if (us_tick) en_ticks <= en_ticks + 1;
      if (!pll_en && p_en) last_en_ticks <= en_ticks;
      if (vco_div == 6'd2 && p_div != 6'd2) gap_ticks <= 0;
      else if (us_tick) gap_ticks <= gap_ticks + 1;
      if (!vco_sel && p_sel) begin
        sel_falls <= sel_falls + 1;
        if (vco_div == 6'd2 && gap_ticks < min_gap) min_gap <= gap_ticks;
      end
      p_req <= ramp_req; p_en <= pll_en; p_sel <= vco_sel; p_div <= vco_div;
    end
  end

  task automatic wait_done();
    int t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!done && t < 20000);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_start(input [7:0] m, input [7:0] n, input [5:0] pl,
                          input int lf, input int rf);
    lock_thr = en_rises + lf;
    ramp_thr = rcnt + rf;
    new_m = m; new_n = n; new_pl = pl;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
  endtask

  task automatic do_shutdown();
    shutdown = 1'b1;
    @(negedge clk);
    shutdown = 1'b0;
    wait_done();
  endtask

  typedef struct packed {
    logic [7:0] m;
    logic [7:0] n;
    logic [5:0] pl;
    logic [1:0] lf;    // lock attempts refused
    logic [1:0] rf;    // ramp requests answered with timeout
    logic [3:0] nr;    // expected ramp requests
    logic [7:0] r0;
    logic [7:0] r1;
    logic [3:0] ens;   // expected enable rises
    logic [7:0] en_n;  // expected N loaded at the last enable
    logic       err;
  } vec_t;

  // ref = 12 MHz: floor(1)=84, floor(2)=167, floor(3)=250
  localparam vec_t VECS [7] = '{
    '{8'd1, 8'd100, 6'd1, 2'd0, 2'd0, 4'd1, 8'd100, 8'd0,   4'd1, 8'd84,  1'b0}, // first relock
    '{8'd1, 8'd120, 6'd1, 2'd0, 2'd0, 4'd1, 8'd120, 8'd0,   4'd0, 8'd0,   1'b0}, // R2 glide only
    '{8'd2, 8'd150, 6'd2, 2'd0, 2'd0, 4'd2, 8'd84,  8'd150, 4'd1, 8'd167, 1'b0}, // R3 old M floor
    '{8'd2, 8'd150, 6'd2, 2'd0, 2'd0, 4'd0, 8'd0,   8'd0,   4'd0, 8'd0,   1'b0}, // R13 same N
    '{8'd3, 8'd200, 6'd1, 2'd1, 2'd0, 4'd1, 8'd167, 8'd0,   4'd2, 8'd200, 1'b0}, // R9 lock retry
    '{8'd1, 8'd90,  6'd3, 2'd2, 2'd0, 4'd1, 8'd250, 8'd0,   4'd2, 8'd90,  1'b1}, // R10 double fail
    '{8'd1, 8'd95,  6'd3, 2'd0, 2'd1, 4'd1, 8'd95,  8'd0,   4'd1, 8'd95,  1'b0}  // R9 ramp retry
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int base_r, base_e, base_f, t5;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset values
    chk("R1 pll_en", pll_en, 0);
    chk("R1 pll_pwrdn", pll_pwrdn, 1);
    chk("R1 lock_det_off", lock_det_off, 1);
    chk("R1 vco_sel", vco_sel, 0);
    chk("R1 vco_div", vco_div, 0);
    chk("R1 byp_div", byp_div, 8'h3c);
    chk("R1 div_mode", div_mode, 1);
    chk("R1 busy", busy, 0);
    chk("R1 error", error, 0);

    t5 = 0;
    for (int i = 0; i < 7; i++) begin
      vec_t v;
      v = VECS[i];
      base_r = rcnt; base_e = en_rises; base_f = sel_falls;
      do_start(v.m, v.n, v.pl, int'(v.lf), int'(v.rf));
      if (i == 4) t5 = last_en_ticks;
      chk("R3 ramp count", rcnt - base_r, int'(v.nr));
      if (v.nr > 0) chk("R3 first ramp target", rlog[base_r % 64], v.r0);
      if (v.nr > 1) chk("R8 second ramp target", rlog[(base_r + 1) % 64], v.r1);
      chk("R9 enable rises", en_rises - base_e, int'(v.ens));
      if (v.ens > 0) chk("R6 N at enable", en_n, v.en_n);
      if (v.ens == 0) chk("R2 no bypass in glide", sel_falls - base_f, 0);
      chk("R6 coef_m", coef_m, v.m);
      chk("R6 coef_n", coef_n, v.n);
      chk("R6 coef_pl", coef_pl, v.pl);
      chk("R10 error", error, v.err);
      chk("R8 vco_sel", vco_sel, v.err ? 0 : 1);
      chk("R8 vco_div", vco_div, v.err ? 2 : 0);
      chk("R5 pll_pwrdn", pll_pwrdn, 0);
      chk("R7 lock_det_off", lock_det_off, 0);
    end
    // R7 lock window length before the retry disables the loop
    chk("R7 lock window >= LOCK_US", (t5 >= 300 && t5 <= 306) ? 1 : 0, 1);
    // R4 settle gap between divide-by-2 and bypass
    chk("R4 bypass gap", (min_gap >= 2 && min_gap < 99) ? 1 : 0, 1);

    // R11 shutdown from an enabled loop
    base_r = rcnt;
    do_shutdown();
    chk("R11 ramp count", rcnt - base_r, 1);
    chk("R11 ramp target", rlog[base_r % 64], 84);
    chk("R11 vco_sel", vco_sel, 0);
    chk("R11 pll_en", pll_en, 0);
    chk("R11 error", error, 0);
    // R11 shutdown from a disabled loop
    base_r = rcnt;
    do_shutdown();
    chk("R11 no ramp when off", rcnt - base_r, 0);
    chk("R11 pll_en stays off", pll_en, 0);

    // R12 commands while busy are ignored
    lock_thr = en_rises;
    ramp_thr = rcnt;
    new_m = 8'd2; new_n = 8'd110; new_pl = 6'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    chk("R12 busy", busy, 1);
    new_m = 8'd5; new_n = 8'd60; new_pl = 6'd4;
    start = 1'b1; shutdown = 1'b1;
    @(negedge clk);
    start = 1'b0; shutdown = 1'b0;
    wait_done();
    chk("R12 coef_m", coef_m, 2);
    chk("R12 coef_n", coef_n, 110);
    chk("R12 coef_pl", coef_pl, 1);
    chk("R12 pll_en", pll_en, 1);
    chk("R12 busy idle", busy, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule